// File: doc/BRIEF.md
# Multi-Slot Interrupt Status Controller

This block merges two interrupt lines from each of up to four module slots into a single host interrupt. Every slot has an 8-bit control byte. Within that byte, each line has its own enable and its own edge/level select. A 16-bit status word reports the state of each line and a per-slot timeout flag. The control bytes and the status word are reached through a small register window at halfword offsets.

The module interrupt lines are asynchronous to the block and pass through a synchronizer. While a line is enabled, its status bit tracks the synchronized level. Level-sensitive lines hold the host output high for as long as any of their status bits is set. A rising edge-sensitive line instead flips the host output for exactly one clock, relative to whatever level it has at that moment.

Software clears a line by requesting that the module drop it. It can do this in two ways. It can write ones to the line's bits in the status word, or it can read acknowledge offset 0 or 2 in a slot's interrupt space. Either way the block emits a one-clock clear pulse toward that slot's line. Timeout flags are set by an external strobe and cleared by writing a one to them.

Top module: `slot_irq_hub`

## Requirements
- R1: After reset, every control byte, every status bit, `host_irq` and `mod_clr` are zero.
- R2: Control byte of slot n sits at byte offset 2*(n+1) and reads back in bits 7:0, with bits 15:8 reading zero. Offsets 0x00 and 0x0A always read zero and ignore writes. Read data appears on `reg_rdata` the clock after the `reg_rd` strobe.
- R3: Control bit 6+i enables line i of its slot. While it is set, status bit 2n+i takes the value of `mod_irq[2n+i]`. A change on that input reaches the status word at the third rising clock edge after it.
- R4: While its enable bit is clear, a status line bit keeps its value whatever its input does.
- R5: Control bit 4+i selects edge (1) or level (0) for line i. `host_irq` is high while any status line bit whose edge select is clear is set, and low otherwise.
- R6: When the status bit of an enabled edge-selected line goes from 0 to 1, `host_irq` is inverted relative to the level of R5 for exactly one clock. A falling edge produces no pulse.
- R7: A write to the status word at offset 0x0C with bit 2n+i set drives `mod_clr[2n+i]` high for exactly the one clock after the write. The write leaves the status line bits themselves unchanged.
- R8: A `slot_tmo[n]` strobe sets status bit 12+n. Writing a one to that bit at 0x0C clears it. Status bits 11:8 always read zero.
- R9: An acknowledge read at offset 0 or 2 of slot s pulses `mod_clr[2s+offset/2]` for the following clock, but only if that status bit is set and the line is level-selected. Any other acknowledge offset produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, valid the clock after `reg_rd` |
| ack_rd | input | 1 | Interrupt-space acknowledge read strobe |
| ack_slot | input | 2 | Slot addressed by the acknowledge read |
| ack_off | input | ACK_OFF_W | Offset within the slot's interrupt space |
| mod_irq | input | 2*NUM_SLOTS | Asynchronous module interrupt lines, index 2n+i |
| slot_tmo | input | NUM_SLOTS | Timeout set strobes, one per slot |
| mod_clr | output | 2*NUM_SLOTS | One-clock clear requests to the module lines |
| host_irq | output | 1 | Shared host interrupt |

## Verification
The assertions take for granted that `slot_tmo[n]` is never strobed in the same clock as a write that clears bit 12+n. They also assume that `ack_slot` names an existing slot. The stimulus changes module lines, strobes and register accesses only on falling clock edges. It raises or drops at most one edge-selected line at a time, so each pulse can be attributed to one source. Acknowledge reads and status writes are issued only while the affected lines are held steady.

// File: rtl/slot_irq_pkg.sv
package slot_irq_pkg;
   localparam int LINES_PER_SLOT = 2;
   localparam int CTL_W          = 8;
   localparam int REG_W          = 16;
   // control byte fields
   localparam int CTL_EDGE_LSB   = 4;
   localparam int CTL_EN_LSB     = 6;
   // status word fields
   localparam int ST_ERR_LSB     = 8;
   localparam int ST_TMO_LSB     = 12;
   // register window (byte offsets)
   localparam int OFF_REV        = 'h00;
   localparam int OFF_CTL0       = 'h02;
   localparam int OFF_RST        = 'h0A;
   localparam int OFF_STAT       = 'h0C;
   // acknowledge offsets in the interrupt space
   localparam int ACK_LINE0      = 0;
   localparam int ACK_LINE1      = 2;
endpackage

// File: rtl/slot_irq_sync.sv
module slot_irq_sync #(
   parameter int WIDTH  = 8,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= din;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/slot_irq_core.sv
module slot_irq_core #(
   parameter int NL = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NL-1:0] line_sync,
   input  logic [NL-1:0] line_en,
   input  logic [NL-1:0] line_edge,
   output logic [NL-1:0] line_stat,
   output logic          host_irq
);
   logic [NL-1:0] stat_q;
   logic [NL-1:0] rise;
   logic          pulse_q;
   logic          level_any;

   // rising status of an enabled edge-selected line
   for (genvar k = 0; k < NL; k++) begin : g_rise
      assign rise[k] = line_en[k] & line_edge[k] & line_sync[k] & ~stat_q[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat_q  <= '0;
         pulse_q <= 1'b0;
      end else begin
         stat_q  <= (stat_q & ~line_en) | (line_sync & line_en);
         pulse_q <= |rise;
      end
   end

   assign level_any = |(stat_q & ~line_edge);
   assign host_irq  = level_any ^ pulse_q;
   assign line_stat = stat_q;
endmodule

// File: rtl/slot_irq_regs.sv
module slot_irq_regs
   import slot_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 8,
   parameter int ACK_OFF_W = 6
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            reg_wr,
   input  logic                            reg_rd,
   input  logic [ADDR_W-1:0]               reg_addr,
   input  logic [REG_W-1:0]                reg_wdata,
   output logic [REG_W-1:0]                reg_rdata,
   input  logic                            ack_rd,
   input  logic [1:0]                      ack_slot,
   input  logic [ACK_OFF_W-1:0]            ack_off,
   input  logic [NUM_SLOTS-1:0]            slot_tmo,
   input  logic [NUM_SLOTS*LINES_PER_SLOT-1:0] line_stat,
   input  logic [NUM_SLOTS*LINES_PER_SLOT-1:0] line_edge,
   output logic [NUM_SLOTS*CTL_W-1:0]      ctrl_flat,
   output logic [NUM_SLOTS-1:0]            tmo_q,
   output logic [NUM_SLOTS*LINES_PER_SLOT-1:0] mod_clr
);
   localparam int NL = NUM_SLOTS * LINES_PER_SLOT;

   logic             stat_wr;
   logic [REG_W-1:0] stat_word;
   logic [REG_W-1:0] rd_val;
   logic [NL-1:0]    clr_d;
   logic             ack_hit;
   logic [3:0]       wdata_unused;

   assign stat_wr      = reg_wr && (reg_addr == ADDR_W'(OFF_STAT));
   assign wdata_unused = reg_wdata[ST_ERR_LSB +: 4];

   // per-slot control bytes and timeout flags
   for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_slot
      localparam logic [ADDR_W-1:0] CTL_OFF = ADDR_W'(OFF_CTL0 + 2*n);
      logic [CTL_W-1:0] ctl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             ctl_q <= '0;
         else if (reg_wr && reg_addr == CTL_OFF) ctl_q <= reg_wdata[CTL_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  tmo_q[n] <= 1'b0;
         else if (slot_tmo[n])                        tmo_q[n] <= 1'b1;
         else if (stat_wr && reg_wdata[ST_TMO_LSB+n]) tmo_q[n] <= 1'b0;
      end

      assign ctrl_flat[n*CTL_W +: CTL_W] = ctl_q;
   end

   always_comb begin
      stat_word                          = '0;
      stat_word[NL-1:0]                  = line_stat;
      stat_word[ST_TMO_LSB +: NUM_SLOTS] = tmo_q;
   end

   always_comb begin
      rd_val = '0;
      if (reg_addr == ADDR_W'(OFF_STAT)) rd_val = stat_word;
      for (int n = 0; n < NUM_SLOTS; n++) begin
         if (reg_addr == ADDR_W'(OFF_CTL0 + 2*n))
            rd_val = {{(REG_W-CTL_W){1'b0}}, ctrl_flat[n*CTL_W +: CTL_W]};
      end
   end

   assign ack_hit = ack_rd && (ack_off == ACK_OFF_W'(ACK_LINE0) ||
                               ack_off == ACK_OFF_W'(ACK_LINE1));

   always_comb begin
      clr_d = stat_wr ? reg_wdata[NL-1:0] : '0;
      for (int k = 0; k < NL; k++) begin
         if (ack_hit && int'(ack_slot) == k / LINES_PER_SLOT &&
             int'(ack_off[1]) == k % LINES_PER_SLOT &&
             line_stat[k] && !line_edge[k])
            clr_d[k] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         mod_clr   <= '0;
      end else begin
         if (reg_rd) reg_rdata <= rd_val;
         mod_clr <= clr_d;
      end
   end
endmodule

// File: rtl/slot_irq_hub.sv
module slot_irq_hub
   import slot_irq_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int SYNC_STAGES = 2,
   parameter int ADDR_W      = 8,
   parameter int ACK_OFF_W   = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   reg_wr,
   input  logic                   reg_rd,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [15:0]            reg_wdata,
   output logic [15:0]            reg_rdata,
   input  logic                   ack_rd,
   input  logic [1:0]             ack_slot,
   input  logic [ACK_OFF_W-1:0]   ack_off,
   input  logic [2*NUM_SLOTS-1:0] mod_irq,
   input  logic [NUM_SLOTS-1:0]   slot_tmo,
   output logic [2*NUM_SLOTS-1:0] mod_clr,
   output logic                   host_irq
);
   localparam int NL = NUM_SLOTS * LINES_PER_SLOT;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("NUM_SLOTS must lie in 1..4 to fit the status word");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("ADDR_W too narrow for the register window");
   end
   if (ACK_OFF_W < 2) begin : g_bad_ack
      $error("ACK_OFF_W too narrow for acknowledge offsets");
   end

   logic [NL-1:0]              line_sync;
   logic [NL-1:0]              line_en;
   logic [NL-1:0]              line_edge;
   logic [NL-1:0]              line_stat;
   logic [NUM_SLOTS-1:0]       tmo_q;
   logic [NUM_SLOTS*CTL_W-1:0] ctrl_flat;
   logic [NUM_SLOTS*4-1:0]     ctrl_misc_unused;

   // split each control byte into per-line enable and edge select
   for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_ctl
      for (genvar i = 0; i < LINES_PER_SLOT; i++) begin : g_line
         assign line_en[n*LINES_PER_SLOT+i]   = ctrl_flat[n*CTL_W + CTL_EN_LSB + i];
         assign line_edge[n*LINES_PER_SLOT+i] = ctrl_flat[n*CTL_W + CTL_EDGE_LSB + i];
      end
      assign ctrl_misc_unused[n*4 +: 4] = ctrl_flat[n*CTL_W +: 4];
   end

   slot_irq_sync #(.WIDTH(NL), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (mod_irq),
      .dout (line_sync)
   );

   slot_irq_core #(.NL(NL)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_sync(line_sync),
      .line_en  (line_en),
      .line_edge(line_edge),
      .line_stat(line_stat),
      .host_irq (host_irq)
   );

   slot_irq_regs #(.NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .ACK_OFF_W(ACK_OFF_W)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_rd   (reg_rd),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .ack_rd   (ack_rd),
      .ack_slot (ack_slot),
      .ack_off  (ack_off),
      .slot_tmo (slot_tmo),
      .line_stat(line_stat),
      .line_edge(line_edge),
      .ctrl_flat(ctrl_flat),
      .tmo_q    (tmo_q),
      .mod_clr  (mod_clr)
   );
endmodule

// File: rtl/slot_irq_hub_chk.sv
module slot_irq_hub_chk
   import slot_irq_pkg::*;
#(
   parameter int NUM_SLOTS = 4,
   parameter int ADDR_W    = 8,
   parameter int ACK_OFF_W = 6
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   reg_wr,
   input logic                   reg_rd,
   input logic [ADDR_W-1:0]      reg_addr,
   input logic [15:0]            reg_wdata,
   input logic [15:0]            reg_rdata,
   input logic                   ack_rd,
   input logic [1:0]             ack_slot,
   input logic [ACK_OFF_W-1:0]   ack_off,
   input logic [NUM_SLOTS-1:0]   slot_tmo,
   input logic [2*NUM_SLOTS-1:0] mod_clr,
   input logic                   host_irq,
   input logic [2*NUM_SLOTS-1:0] line_sync,
   input logic [2*NUM_SLOTS-1:0] line_en,
   input logic [2*NUM_SLOTS-1:0] line_edge,
   input logic [2*NUM_SLOTS-1:0] line_stat,
   input logic [NUM_SLOTS-1:0]   tmo_q
);
   localparam int NL = 2 * NUM_SLOTS;

   a_r2_fixed_zero: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_rd && (reg_addr == ADDR_W'(OFF_REV) || reg_addr == ADDR_W'(OFF_RST)))
         |-> reg_rdata == 16'h0000);

   a_r5_level_out: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(|(line_en & line_edge & line_sync & ~line_stat))
         |-> host_irq == |(line_stat & ~line_edge));

   a_r6_edge_flip: assert property (@(posedge clk) disable iff (!rst_n)
      $past(|(line_en & line_edge & line_sync & ~line_stat))
         |-> host_irq != |(line_stat & ~line_edge));

   for (genvar k = 0; k < NL; k++) begin : g_line
      a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
         $past(line_en[k]) |-> line_stat[k] == $past(line_sync[k]));

      a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(line_en[k]) |-> line_stat[k] == $past(line_stat[k]));

      // R7 status write or R9 acknowledge must precede every clear pulse
      a_r7_clr_cause: assert property (@(posedge clk) disable iff (!rst_n)
         mod_clr[k] |->
            ($past(reg_wr && reg_addr == ADDR_W'(OFF_STAT) && reg_wdata[k]) ||
             $past(ack_rd && ack_off == ACK_OFF_W'(2*(k%2)) && ack_slot == 2'(k/2) &&
                   line_stat[k] && !line_edge[k])));
   end

   for (genvar n = 0; n < NUM_SLOTS; n++) begin : g_tmo
      a_r8_tmo_set: assert property (@(posedge clk) disable iff (!rst_n)
         $past(slot_tmo[n]) |-> tmo_q[n]);

      a_r8_tmo_clear: assert property (@(posedge clk) disable iff (!rst_n)
         $past(reg_wr && reg_addr == ADDR_W'(OFF_STAT) && reg_wdata[ST_TMO_LSB+n] && !slot_tmo[n])
            |-> !tmo_q[n]);
   end
endmodule

bind slot_irq_hub slot_irq_hub_chk #(
   .NUM_SLOTS(NUM_SLOTS), .ADDR_W(ADDR_W), .ACK_OFF_W(ACK_OFF_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_rd(ack_rd), .ack_slot(ack_slot),
   .ack_off(ack_off), .slot_tmo(slot_tmo), .mod_clr(mod_clr), .host_irq(host_irq),
   .line_sync(line_sync), .line_en(line_en), .line_edge(line_edge),
   .line_stat(line_stat), .tmo_q(tmo_q)
);

// File: tb/slot_irq_hub_tb.sv
module slot_irq_hub_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ack_rd = 1'b0;
   logic [1:0]  ack_slot = '0;
   logic [5:0]  ack_off = '0;
   logic [7:0]  mod_irq = '0;
   logic [3:0]  slot_tmo = '0;
   logic [7:0]  mod_clr;
   logic        host_irq;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #5 clk = ~clk;

   slot_irq_hub u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ack_rd(ack_rd), .ack_slot(ack_slot),
      .ack_off(ack_off), .mod_irq(mod_irq), .slot_tmo(slot_tmo), .mod_clr(mod_clr),
      .host_irq(host_irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] a, input logic [15:0] d, output logic [7:0] clr);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      clr = mod_clr;
   endtask

   task automatic rd(input logic [7:0] a, output logic [15:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic ack(input int s, input int o, output logic [7:0] clr);
      ack_rd = 1'b1; ack_slot = 2'(s); ack_off = 6'(o);
      @(negedge clk);
      ack_rd = 1'b0;
      clr = mod_clr;
   endtask

   // drive every line low, enable all so status empties, then disable all
   task automatic flush();
      logic [7:0] c;
      mod_irq = '0;
      for (int s = 0; s < 4; s++) wr(8'(2*(s+1)), 16'h00C0, c);
      tick(3);
      for (int s = 0; s < 4; s++) wr(8'(2*(s+1)), 16'h0000, c);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic [7:0]  c;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk(host_irq == 1'b0, "R1 host_irq", host_irq, 0);
      chk(mod_clr == 8'h00, "R1 mod_clr", mod_clr, 0);
      for (int s = 0; s < 4; s++) begin
         rd(8'(2*(s+1)), d);
         chk(d == 16'h0, "R1 ctrl", d, 0);
      end
      rd(8'h0C, d);
      chk(d == 16'h0, "R1 status", d, 0);

      // R2 register map
      for (int s = 0; s < 4; s++) wr(8'(2*(s+1)), 16'hA500 | 16'(8'h13 + 8'(s*17)), c);
      for (int s = 0; s < 4; s++) begin
         rd(8'(2*(s+1)), d);
         chk(d == 16'(8'h13 + 8'(s*17)), "R2 ctrl readback", d, 16'(8'h13 + 8'(s*17)));
      end
      wr(8'h00, 16'hFFFF, c);
      wr(8'h0A, 16'hFFFF, c);
      rd(8'h00, d); chk(d == 16'h0, "R2 revision", d, 0);
      rd(8'h0A, d); chk(d == 16'h0, "R2 reset reg", d, 0);
      flush();

      // R3 R4 R5 R6 sweep: every line, every enable/edge mode
      for (int k = 0; k < 8; k++) begin
         for (int m = 0; m < 4; m++) begin
            bit en = m[0];
            bit ed = m[1];
            int n  = k / 2;
            int i  = k % 2;
            logic [15:0] cfg;
            cfg = 16'((int'(en) << (6+i)) | (int'(ed) << (4+i)));
            flush();
            wr(8'(2*(n+1)), cfg, c);
            mod_irq[k] = 1'b1;
            tick(3);
            chk(host_irq == en, ed ? "R6 edge pulse" : "R5 level rise", host_irq, en);
            tick(1);
            chk(host_irq == (en && !ed), ed ? "R6 pulse one clock" : "R5 level held",
                host_irq, en && !ed);
            rd(8'h0C, d);
            chk(d[7:0] == 8'(int'(en) << k), "R3 status follows enabled line", d[7:0],
                int'(en) << k);
            if (en) begin
               wr(8'(2*(n+1)), 16'h0000, c);
               mod_irq[k] = 1'b0;
               tick(3);
               rd(8'h0C, d);
               chk(d[k] == 1'b1, "R4 disabled line holds", d[k], 1);
               chk(host_irq == 1'b1, "R5 held bit with level select", host_irq, 1);
               wr(8'(2*(n+1)), cfg, c);
               tick(1);
               rd(8'h0C, d);
               chk(d[k] == 1'b0, "R3 status resyncs on enable", d[k], 0);
            end else begin
               mod_irq[k] = 1'b0;
               tick(3);
               rd(8'h0C, d);
               chk(d[k] == 1'b0, "R4 disabled line ignored", d[k], 0);
            end
            chk(host_irq == 1'b0, "R5 output low after drop", host_irq, 0);
         end
      end

      // R6 pulse against asserted level, and no pulse on falling edge
      flush();
      wr(8'h02, 16'h0040, c);
      mod_irq[0] = 1'b1;
      tick(3);
      chk(host_irq == 1'b1, "R5 level asserted", host_irq, 1);
      wr(8'h04, 16'h00A0, c);
      mod_irq[3] = 1'b1;
      tick(3);
      chk(host_irq == 1'b0, "R6 inverted pulse", host_irq, 0);
      tick(1);
      chk(host_irq == 1'b1, "R6 level restored", host_irq, 1);
      mod_irq[3] = 1'b0;
      tick(3);
      chk(host_irq == 1'b1, "R6 no pulse on fall", host_irq, 1);
      tick(1);
      chk(host_irq == 1'b1, "R6 no pulse on fall +1", host_irq, 1);

      // R7 clear requests through the status word
      flush();
      for (int s = 0; s < 4; s++) wr(8'(2*(s+1)), 16'h00C0, c);
      mod_irq = 8'hFF;
      tick(3);
      for (int k = 0; k < 8; k++) begin
         wr(8'h0C, 16'(1 << k), c);
         chk(c == 8'(1 << k), "R7 clear pulse", c, 1 << k);
         tick(1);
         chk(mod_clr == 8'h00, "R7 pulse one clock", mod_clr, 0);
      end
      wr(8'h0C, 16'h0000, c);
      chk(c == 8'h00, "R7 zero write no pulse", c, 0);
      rd(8'h0C, d);
      chk(d == 16'h00FF, "R7 status unchanged by write", d, 16'h00FF);

      // R8 timeout flags and error field
      for (int n = 0; n < 4; n++) begin
         slot_tmo[n] = 1'b1;
         tick(1);
         slot_tmo[n] = 1'b0;
         rd(8'h0C, d);
         chk(d[12+n] == 1'b1, "R8 timeout set", d, 16'h00FF | (1 << (12+n)));
         wr(8'h0C, 16'h0F00, c);
         rd(8'h0C, d);
         chk(d == 16'(16'h00FF | (1 << (12+n))), "R8 error bits zero and ignored", d,
             16'h00FF | (1 << (12+n)));
         wr(8'h0C, 16'(1 << (12+n)), c);
         chk(c == 8'h00, "R8 timeout clear no line pulse", c, 0);
         rd(8'h0C, d);
         chk(d == 16'h00FF, "R8 timeout cleared", d, 16'h00FF);
      end

      // R9 acknowledge reads: line0 level, line1 edge, then line1 level
      for (int n = 0; n < 4; n++) wr(8'(2*(n+1)), 16'h00E0, c);
      for (int n = 0; n < 4; n++) begin
         for (int o = 0; o < 5; o++) begin
            logic [7:0] e;
            e = (o == 0) ? 8'(1 << (2*n)) : 8'h00;
            ack(n, o, c);
            chk(c == e, "R9 ack with edge line1", c, e);
         end
      end
      for (int n = 0; n < 4; n++) wr(8'(2*(n+1)), 16'h00C0, c);
      for (int n = 0; n < 4; n++) begin
         ack(n, 2, c);
         chk(c == 8'(1 << (2*n+1)), "R9 ack line1 level", c, 1 << (2*n+1));
         tick(1);
         chk(mod_clr == 8'h00, "R9 pulse one clock", mod_clr, 0);
      end
      mod_irq = 8'h00;
      tick(3);
      ack(1, 0, c);
      chk(c == 8'h00, "R9 ack with clear status", c, 0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end
endmodule